// File: doc/BRIEF.md
# Interval Timer and Watchdog

The block combines a periodic interval timer and a watchdog for a line-interface controller. A shared prescaler divides the system clock into a base tick (3.125 ms at the default setting). Two counters run from that tick. The timer counts up to its terminal value, emits a one-clock interrupt pulse, reloads and keeps running. The watchdog counts up to its own terminal value and then raises a reset request that stays high. Host software must restart the block in time to keep that request low.

The host writes one control word made of three fields: a 3-bit period select, an automatic-restart mode bit and a restart command bit. The select picks a timer period and a watchdog period together, from a fixed, non-linear table. The restart command bit clears itself one clock after it is written. In automatic mode, every host bus access, signalled on `hostAccess`, also restarts both counters. A change of select restarts both counters, so a new period always counts from zero.

Top module: `ivl_wdt`

## Requirements
- R1: After reset, `timerIrq` and `wdReq` are 0, and the readback shows select 000, `rdAuto` 0 and `rdKick` 0.
- R2: Timer period in base ticks for each select value: 0→1, 1→2, 2→4, 3→8, 4→16, 5→128, 6→256. Select 7 turns the timer off. One base tick is `CLKS_PER_TICK` clocks.
- R3: Watchdog period in base ticks for each select value: 1→2, 2→4, 3→8, 4→16, 5→32, 6→256, 7→512. Select 0 turns the watchdog off.
- R4: After a restart at clock edge E, `timerIrq` goes high for exactly one clock after edge E + k·T·`CLKS_PER_TICK`, for every k ≥ 1, where T is the timer period in ticks.
- R5: `wdReq` rises after edge E + W·`CLKS_PER_TICK`, where W is the watchdog period in ticks. It then stays high until a restart or a reset.
- R6: A control write with `cfgKick`=1 restarts the prescaler and both counters, clears `wdReq`, and suppresses a timer pulse on that edge.
- R7: `rdKick` reads 1 for exactly the one clock after a write with `cfgKick`=1. It reads 0 after that, and after any write with `cfgKick`=0.
- R8: While `rdAuto` is 0, pulses on `hostAccess` have no effect on the timer or watchdog timing.
- R9: While `rdAuto` is 1, each clock with `hostAccess` high restarts the block as in R6.
- R10: A write whose `cfgSel` differs from `rdSel` restarts the block. A write with the same select and `cfgKick`=0 does not change the timing.
- R11: While its period is off, a counter produces no output: no timer pulse at select 7, and no watchdog request at select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Control word write strobe |
| cfgSel | input | 3 | Period select written on `cfgWe` |
| cfgAuto | input | 1 | Automatic-restart mode written on `cfgWe` |
| cfgKick | input | 1 | Restart command; acts when written as 1 |
| hostAccess | input | 1 | High for one clock on any host bus access |
| rdSel | output | 3 | Current period select |
| rdAuto | output | 1 | Current automatic-restart mode |
| rdKick | output | 1 | Self-clearing restart bit readback |
| timerIrq | output | 1 | Periodic one-clock interrupt pulse |
| wdReq | output | 1 | Sticky watchdog reset request |

## Verification
The assertions check on every cycle these rules:
- a timer pulse is never longer than one clock;
- the watchdog request holds until a restart;
- a restart zeroes both counters and clears both outputs;
- a disabled counter stays silent;
- the restart bit readback clears itself.

Only the bench scenarios can show the rest. They measure the exact cycle of every pulse and request for all eight select values, and they show how host accesses act in each mode. They also show that a select change re-zeroes the counters while a rewrite of the same select does not.

// File: rtl/ivl_wdt_pkg.sv
package ivl_wdt_pkg;
  // Ticks are counted in a width that holds the longest period (512 ticks).
  localparam int TICK_W = 10;
  localparam int SEL_W  = 3;

  typedef logic [TICK_W-1:0] tick_t;
  typedef logic [SEL_W-1:0]  sel_t;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic  restart;
    logic  timerEn;
    logic  wdEn;
    tick_t timerTerm;
    tick_t wdTerm;
  } strobe_t;

  // Timer period in base ticks; 0 means off.
  function automatic tick_t timerTicks(input sel_t sel);
    case (sel)
      3'd5:    return tick_t'(128);
      3'd6:    return tick_t'(256);
      3'd7:    return tick_t'(0);
      default: return tick_t'(1) << sel;
    endcase
  endfunction

  // Watchdog period in base ticks; 0 means off.
  function automatic tick_t wdTicks(input sel_t sel);
    case (sel)
      3'd0:    return tick_t'(0);
      3'd6:    return tick_t'(256);
      3'd7:    return tick_t'(512);
      default: return tick_t'(1) << sel;
    endcase
  endfunction
endpackage

// File: rtl/ivl_wdt_ctrl.sv
module ivl_wdt_ctrl
  import ivl_wdt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgWe,
  input  sel_t    cfgSel,
  input  logic    cfgAuto,
  input  logic    cfgKick,
  input  logic    hostAccess,
  output sel_t    selQ,
  output logic    autoQ,
  output logic    kickQ,
  output strobe_t strb
);
  logic kickWr, selChg, autoHit;

  // Control word; the restart bit lives for one clock only.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      autoQ <= 1'b0;
      kickQ <= 1'b0;
    end else begin
      kickQ <= cfgWe && cfgKick;
      if (cfgWe) begin
        selQ  <= cfgSel;
        autoQ <= cfgAuto;
      end
    end
  end

  always_comb begin
    kickWr         = cfgWe && cfgKick;
    selChg         = cfgWe && (cfgSel != selQ);
    autoHit        = autoQ && hostAccess;
    strb.restart   = kickWr || selChg || autoHit;
    strb.timerTerm = timerTicks(selQ);
    strb.wdTerm    = wdTicks(selQ);
    strb.timerEn   = (strb.timerTerm != '0);
    strb.wdEn      = (strb.wdTerm != '0);
  end

  // R7: the restart readback drops one clock after it was set
  a_r7_kick_selfclear: assert property (@(posedge clk) disable iff (!rstN)
    (kickQ && !(cfgWe && cfgKick)) |=> !kickQ);
endmodule

// File: rtl/ivl_wdt_dp.sv
module ivl_wdt_dp
  import ivl_wdt_pkg::*;
#(
  parameter int CLKS_PER_TICK = 156250  // must be at least 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  output logic    timerIrq,
  output logic    wdReq
);
  localparam int    PRE_W    = (CLKS_PER_TICK > 2) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);
  localparam tick_t ONE      = tick_t'(1);

  logic [PRE_W-1:0] preCnt;
  tick_t            tmrCnt, wdCnt;
  logic             tick, tmrHit, wdHit;

  assign tick   = (preCnt == PRE_LAST);
  assign tmrHit = tick && strb.timerEn && (tmrCnt == strb.timerTerm - ONE);
  assign wdHit  = tick && strb.wdEn && !wdReq && (wdCnt == strb.wdTerm - ONE);

  // Base tick prescaler; realigned on every restart.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (strb.restart || tick) preCnt <= '0;
    else                      preCnt <= preCnt + 1'b1;
  end

  // Periodic timer with auto-reload.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt   <= '0;
      timerIrq <= 1'b0;
    end else if (strb.restart || !strb.timerEn) begin
      tmrCnt   <= '0;
      timerIrq <= 1'b0;
    end else begin
      timerIrq <= tmrHit;
      if (tick) tmrCnt <= tmrHit ? '0 : tmrCnt + ONE;
    end
  end

  // Watchdog with a sticky request.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt <= '0;
      wdReq <= 1'b0;
    end else if (strb.restart || !strb.wdEn) begin
      wdCnt <= '0;
      wdReq <= 1'b0;
    end else if (wdHit) begin
      wdCnt <= '0;
      wdReq <= 1'b1;
    end else if (tick && !wdReq) begin
      wdCnt <= wdCnt + ONE;
    end
  end

  // R4: a timer pulse lasts one clock
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq |=> !timerIrq);
  // R5: the request holds until a restart
  a_r5_wd_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wdReq && !strb.restart) |=> wdReq);
  // R6: a restart zeroes the counters and clears both outputs
  a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (!wdReq && !timerIrq && tmrCnt == '0 && wdCnt == '0 && preCnt == '0));
  // R11: a period that is off produces nothing
  a_r11_timer_off: assert property (@(posedge clk) disable iff (!rstN)
    !strb.timerEn |-> !timerIrq);
  a_r11_wd_off: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wdEn |-> !wdReq);
endmodule

// File: rtl/ivl_wdt.sv
module ivl_wdt
  import ivl_wdt_pkg::*;
#(
  parameter int CLKS_PER_TICK = 156250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [2:0] cfgSel,
  input  logic       cfgAuto,
  input  logic       cfgKick,
  input  logic       hostAccess,
  output logic [2:0] rdSel,
  output logic       rdAuto,
  output logic       rdKick,
  output logic       timerIrq,
  output logic       wdReq
);
  strobe_t strb;

  ivl_wdt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgSel     (cfgSel),
    .cfgAuto    (cfgAuto),
    .cfgKick    (cfgKick),
    .hostAccess (hostAccess),
    .selQ       (rdSel),
    .autoQ      (rdAuto),
    .kickQ      (rdKick),
    .strb       (strb)
  );

  ivl_wdt_dp #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .timerIrq (timerIrq),
    .wdReq    (wdReq)
  );
endmodule

// File: tb/ivl_wdt_bench.sv
`timescale 1ns/1ps
module ivl_wdt_bench;
  localparam int P = 4;

  logic       clk = 1'b0, rstN = 1'b0;
  logic       cfgWe = 1'b0, cfgAuto = 1'b0, cfgKick = 1'b0, hostAccess = 1'b0;
  logic [2:0] cfgSel = '0;
  logic [2:0] rdSel;
  logic       rdAuto, rdKick, timerIrq, wdReq;

  int cyc = 0;
  int checks = 0, fails = 0;
  int expIrq[$];
  int expWd[$];
  int eI;
  logic wdPrev = 1'b0;

  ivl_wdt #(.CLKS_PER_TICK(P)) u_ivl_wdt (.*);

  always #10 clk = ~clk;

  always @(posedge clk or negedge rstN)
    if (!rstN) cyc <= 0; else cyc <= cyc + 1;

  // Periods taken from R2 and R3, in base ticks (0 = off).
  function automatic int tTicks(input int s);
    case (s) 0: return 1; 1: return 2; 2: return 4; 3: return 8;
      4: return 16; 5: return 128; 6: return 256; default: return 0; endcase
  endfunction
  function automatic int wTicks(input int s);
    case (s) 1: return 2; 2: return 4; 3: return 8; 4: return 16;
      5: return 32; 6: return 256; 7: return 512; default: return 0; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pops expected events as the design produces them.
  always @(negedge clk) begin
    if (rstN) begin
      if (timerIrq) begin
        checks++;
        if (expIrq.size() == 0) begin
          fails++;
          $display("FAIL R4 unexpected timer pulse actual=%0d expected=none", cyc);
        end else begin
          eI = expIrq.pop_front();
          if (eI != cyc) begin
            fails++;
            $display("FAIL R2 timer pulse cycle actual=%0d expected=%0d", cyc, eI);
          end
        end
      end
      if (wdReq && !wdPrev) begin
        checks++;
        if (expWd.size() == 0) begin
          fails++;
          $display("FAIL R5 unexpected watchdog request actual=%0d expected=none", cyc);
        end else begin
          eI = expWd.pop_front();
          if (eI != cyc) begin
            fails++;
            $display("FAIL R3 watchdog request cycle actual=%0d expected=%0d", cyc, eI);
          end
        end
      end
    end
    wdPrev = wdReq;
  end

  // Driver: one control write; returns the cycle count of the edge that took it.
  task automatic cfgWrite(input int s, input bit a, input bit k, output int edgeCyc);
    cfgWe = 1'b1; cfgSel = 3'(s); cfgAuto = a; cfgKick = k;
    @(posedge clk); #1;
    edgeCyc = cyc;
    cfgWe = 1'b0; cfgKick = 1'b0;
  endtask

  task automatic pushExp(input int st, input int s, input int endC);
    int t = tTicks(s) * P;
    int w = wTicks(s) * P;
    if (t > 0)
      for (int c = st + t; c <= endC; c += t) expIrq.push_back(c);
    if (w > 0 && st + w <= endC) expWd.push_back(st + w);
  endtask

  task automatic waitCyc(input int c);
    while (cyc < c) @(negedge clk);
    #1;
  endtask

  task automatic drained(input string req);
    chk(expIrq.size() == 0 && expWd.size() == 0, req,
        expIrq.size() + expWd.size(), 0);
    expIrq.delete();
    expWd.delete();
  endtask

  task automatic hostPulse();
    hostAccess = 1'b1;
    @(posedge clk); #1;
    hostAccess = 1'b0;
  endtask

  initial begin
    int st, st2, endC, win, dummy;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(timerIrq == 0, "R1 timerIrq", timerIrq, 0);
    chk(wdReq == 0, "R1 wdReq", wdReq, 0);
    chk(rdSel == 0 && rdAuto == 0, "R1 readback sel/auto", {rdSel, rdAuto}, 0);
    chk(rdKick == 0, "R1 rdKick", rdKick, 0);

    // R2 R3 R4 R5 R11: every select value
    for (int s = 0; s < 8; s++) begin
      cfgWrite(s, 1'b0, 1'b1, st);
      if (s == 0) begin
        chk(rdKick == 1, "R7 kick readback set", rdKick, 1);
        @(posedge clk); #1;
        chk(rdKick == 0, "R7 kick readback cleared", rdKick, 0);
      end
      chk(rdSel == 3'(s), "R2 select readback", rdSel, s);
      win  = (2 * tTicks(s) * P > wTicks(s) * P) ? 2 * tTicks(s) * P : wTicks(s) * P;
      endC = st + win + 6;
      pushExp(st, s, endC);
      waitCyc(endC);
      drained("R2/R3 events drained");
      if (wTicks(s) > 0) chk(wdReq == 1, "R5 request held", wdReq, 1);
      else               chk(wdReq == 0, "R11 watchdog off", wdReq, 0);
    end

    // R6: explicit restart clears a raised request
    chk(wdReq == 1, "R6 precondition", wdReq, 1);
    cfgWrite(1, 1'b0, 1'b1, st);
    chk(wdReq == 0, "R6 restart clears request", wdReq, 0);

    // R8: host accesses ignored in manual mode
    endC = st + 30;
    pushExp(st, 1, endC);
    waitCyc(st + 2);
    hostPulse();
    waitCyc(st + 5);
    hostPulse();
    waitCyc(endC);
    drained("R8 manual mode timing");

    // R9: host accesses restart in automatic mode
    cfgWrite(2, 1'b1, 1'b1, st);
    chk(rdAuto == 1, "R9 auto readback", rdAuto, 1);
    for (int i = 0; i < 5; i++) begin
      waitCyc(st + 9);
      hostPulse();
      st = cyc;
    end
    chk(wdReq == 0 && expIrq.size() == 0, "R9 no event while accessed", wdReq, 0);
    endC = st + 40;
    pushExp(st, 2, endC);
    waitCyc(endC);
    drained("R9 auto restart timing");

    // R10: select change restarts without the restart bit
    cfgWrite(3, 1'b0, 1'b1, st);
    waitCyc(st + 20);
    cfgWrite(4, 1'b0, 1'b0, st2);
    chk(rdKick == 0, "R7 no kick readback", rdKick, 0);
    endC = st2 + 140;
    pushExp(st2, 4, endC);
    waitCyc(endC);
    drained("R10 select change restart");

    // R10: same select rewrite without restart bit has no effect
    cfgWrite(4, 1'b0, 1'b1, st);
    waitCyc(st + 40);
    cfgWrite(4, 1'b0, 1'b0, dummy);
    endC = st + 140;
    pushExp(st, 4, endC);
    waitCyc(endC);
    drained("R10 same select no effect");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule